// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is a small execution core built around one shared 16-bit internal bus. It holds four general registers (AX, BX, CX, DX), an operand latch Y in front of the adder and a result latch Z behind it. Instructions arrive as a stream of bytes: one opcode byte, then a register-selector byte where the opcode needs one, then zero, one or two immediate bytes. Once the last byte is in, a sequencer runs the instruction as a series of steps. Each step moves exactly one value across the bus.

Because only one value can sit on the bus in a cycle, a two-operand arithmetic operation cannot finish in one transfer. It takes three: the destination is copied into Y, Y is combined with the second operand into Z, and Z is written back. A register exchange also takes three transfers, using Z as the parking place. A plain move takes one transfer. Every register can be read or written as a full word or as either of its two byte lanes. A one-cycle `done` pulse marks the completion of the final transfer. A one-cycle `err` pulse rejects an encoding the block does not execute, and no register changes when that happens.

Top module: `sbus_core`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0, `done` and `err` are 0, and `in_ready` is 1.
- R2: Byte register codes are AL=0, CL=1, DL=2, BL=3, AH=4, CH=5, DH=6, BH=7. A high byte is bits 15:8 of its register and a low byte is bits 7:0. A byte write leaves the other lane of that register unchanged. Byte moves use opcode 8A with a selector byte, and byte immediate loads use opcode B0+code followed by one byte.
- R3: Opcodes B8, B9, BA and BB, each followed by two immediate bytes sent low byte first, load AX, CX, DX and BX respectively. The load takes one transfer.
- R4: Opcode 8B followed by a selector byte copies one word register into another in one transfer. The selector byte has bits 7:6 = 11, a destination code in bits 5:3 and a source code in bits 2:0. Word codes are AX=0, CX=1, DX=2, BX=3.
- R5: Opcodes 03 (add) and 2B (subtract) operate on words, and 02 and 2A do the same on bytes. Each uses the R4 selector layout and computes dest ← dest ± source modulo the operand width. The instruction runs as three transfers, and the result appears only with the third.
- R6: Opcode 05 followed by a 16-bit immediate adds that immediate to AX. Opcode 83 with selector bits 5:3 = 0 adds a sign-extended 8-bit immediate to the word register named in bits 2:0. The same opcode with bits 5:3 = 5 subtracts that immediate instead. Both forms take three transfers.
- R7: Opcodes 40, 41, 42 and 43 increment AX, CX, DX and BX by one, wrapping from FFFF to 0. Each increment takes three transfers.
- R8: Opcodes 87 (word) and 86 (byte) swap the two registers named by the selector byte. The register named in bits 5:3 takes its new value at the second transfer, and the register named in bits 2:0 takes its new value at the third.
- R9: `in_ready` is 1 while bytes are being collected and 0 while steps execute. Bytes offered while it is 0 are ignored. `done` is a one-cycle pulse in the cycle that shows the final results, and `in_ready` is 1 in that cycle.
- R10: The following encodings are rejected:
  - an unknown opcode, including BC–BF and 44–47;
  - a selector byte whose bits 7:6 are not 11;
  - a word code of 4–7;
  - an 83 selector byte whose bits 5:3 are neither 0 nor 5.

  A rejection pulses `err` for the one cycle after the offending byte. No register changes, and the next byte is taken as an opcode.
- R11: At most one of the four registers changes in any clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | The block accepts a byte this cycle |
| done | output | 1 | Final transfer of an instruction has completed |
| err | output | 1 | The last byte made the instruction unexecutable |
| ax_q | output | 16 | Register AX |
| bx_q | output | 16 | Register BX |
| cx_q | output | 16 | Register CX |
| dx_q | output | 16 | Register DX |

## Verification
The bench aims at the orderings that a single bus forces:
- An add or subtract that writes back one step early, or an exchange that updates both registers together, shows up in the per-cycle register comparison.
- A byte write that clears the other lane, or a byte sum whose carry leaks into the high lane, leaves a wrong high byte.
- An immediate that is zero-extended gives the wrong result for 83 with FF and 80.
- A 16-bit immediate assembled in the wrong byte order loads a byte-swapped word.
- A decoder that acts on a rejected selector byte, or accepts bytes offered during execution, changes a register that the model holds still.

// File: rtl/sbus_pkg.sv
// Package: shared widths, encodings and control types for the single-bus core.
// Assumes a byte-wide instruction stream and a word of two bytes.
package sbus_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NREGS  = 4;
    localparam int IDX_W  = $clog2(NREGS);
    localparam int CODE_W = IDX_W + 1;
    localparam int STEP_W = 2;

    typedef enum logic [1:0] {K_MOV, K_ALU, K_XCHG} kind_e;
    typedef enum logic [2:0] {B_NONE, B_RDST, B_RSRC, B_IMM, B_Z} bsrc_e;
    typedef enum logic [1:0] {Z_PASS, Z_ADD, Z_SUB} zop_e;
    typedef enum logic [1:0] {W_NONE, W_DST, W_SRC} wsel_e;

    // one bus transfer: who drives, who captures
    typedef struct packed {
        bsrc_e bus_src;
        wsel_e wr_sel;
        logic  y_ld;
        logic  z_ld;
        zop_e  z_op;
        logic  last;
    } ustep_t;

    // decoded instruction held by the sequencer
    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic              wide;
        logic              sub;
        logic              need_sel;
        logic              rm_ext;
        logic [1:0]        imm_bytes;
        logic              imm_sext;
        logic              src_imm;
        logic [CODE_W-1:0] dst;
        logic [CODE_W-1:0] src;
    } dec_t;
endpackage

// File: rtl/sbus_regfile.sv
// Register file: four word registers, one read port and one write port.
// Each port addresses a full word or a byte lane. Code bits [IDX_W-1:0] pick
// the register; for byte access the top code bit picks the high lane.
// Assumes the caller never asks for a word access with the top code bit set.
module sbus_regfile
    import sbus_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CODE_W-1:0]            rd_code,
    input  logic                         rd_wide,
    output logic [WORD_W-1:0]            rd_data,
    input  logic                         wr_en,
    input  logic [CODE_W-1:0]            wr_code,
    input  logic                         wr_wide,
    input  logic [WORD_W-1:0]            wr_data,
    output logic [NREGS-1:0][WORD_W-1:0] regs_o
);
    logic [NREGS-1:0][WORD_W-1:0] regs_q;
    logic [WORD_W-1:0]            sel_word;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        // store one register, honouring the byte lane on a narrow write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (wr_en && (wr_code[IDX_W-1:0] == IDX_W'(g))) begin
                if (wr_wide)
                    regs_q[g] <= wr_data;
                else if (wr_code[CODE_W-1])
                    regs_q[g][WORD_W-1:BYTE_W] <= wr_data[BYTE_W-1:0];
                else
                    regs_q[g][BYTE_W-1:0] <= wr_data[BYTE_W-1:0];
            end
        end
    end

    // read port: whole word, or one lane zero-extended onto the bus
    always_comb begin
        sel_word = regs_q[rd_code[IDX_W-1:0]];
        if (rd_wide)
            rd_data = sel_word;
        else if (rd_code[CODE_W-1])
            rd_data = {{BYTE_W{1'b0}}, sel_word[WORD_W-1:BYTE_W]};
        else
            rd_data = {{BYTE_W{1'b0}}, sel_word[BYTE_W-1:0]};
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/sbus_alu.sv
// Arithmetic stage with its two latches.
// Y captures the bus. Z captures Y+bus, Y-bus, or the bus unchanged.
// A byte-width result is zero-extended so the high lane never carries.
module sbus_alu
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] bus,
    input  logic              y_ld,
    input  logic              z_ld,
    input  zop_e              z_op,
    input  logic              wide,
    output logic [WORD_W-1:0] z_q
);
    logic [WORD_W-1:0] y_q;
    logic [WORD_W-1:0] res;

    // combine Y with the bus value and trim to the operand width
    always_comb begin
        case (z_op)
            Z_ADD:   res = y_q + bus;
            Z_SUB:   res = y_q - bus;
            default: res = bus;
        endcase
        if (!wide)
            res[WORD_W-1:BYTE_W] = '0;
    end

    // latch Y and Z when their step asks for it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_q <= '0;
            z_q <= '0;
        end else begin
            if (y_ld) y_q <= bus;
            if (z_ld) z_q <= res;
        end
    end
endmodule

// File: rtl/sbus_ustep.sv
// Step table: maps (instruction kind, step number) to the controls of one
// bus transfer. It is purely combinational, and every output is idle when
// exec is low.
// Assumes step only counts up to the step flagged last.
module sbus_ustep
    import sbus_pkg::*;
(
    input  logic              exec,
    input  kind_e             kind,
    input  logic              src_imm,
    input  logic              sub,
    input  logic [STEP_W-1:0] step,
    output ustep_t            u
);
    // choose the driver and captors for the current transfer
    always_comb begin
        u.bus_src = B_NONE;
        u.wr_sel  = W_NONE;
        u.y_ld    = 1'b0;
        u.z_ld    = 1'b0;
        u.z_op    = Z_PASS;
        u.last    = 1'b0;
        if (exec) begin
            case (kind)
                K_MOV: begin
                    u.bus_src = src_imm ? B_IMM : B_RSRC;
                    u.wr_sel  = W_DST;
                    u.last    = 1'b1;
                end
                K_ALU: begin
                    case (step)
                        2'd0: begin
                            u.bus_src = B_RDST;
                            u.y_ld    = 1'b1;
                        end
                        2'd1: begin
                            u.bus_src = src_imm ? B_IMM : B_RSRC;
                            u.z_ld    = 1'b1;
                            u.z_op    = sub ? Z_SUB : Z_ADD;
                        end
                        default: begin
                            u.bus_src = B_Z;
                            u.wr_sel  = W_DST;
                            u.last    = 1'b1;
                        end
                    endcase
                end
                default: begin
                    case (step)
                        2'd0: begin
                            u.bus_src = B_RDST;
                            u.z_ld    = 1'b1;
                        end
                        2'd1: begin
                            u.bus_src = B_RSRC;
                            u.wr_sel  = W_DST;
                        end
                        default: begin
                            u.bus_src = B_Z;
                            u.wr_sel  = W_SRC;
                            u.last    = 1'b1;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/sbus_seq.sv
// Byte collector and step sequencer. It takes an opcode, an optional
// register-selector byte and 0-2 immediate bytes (low byte first), rejects
// encodings it cannot execute, then walks the steps until the last one.
// Assumes the step table raises last on the final transfer of each kind.
module sbus_seq
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              last,
    output logic              in_ready,
    output logic              exec,
    output dec_t              dec,
    output logic [WORD_W-1:0] imm,
    output logic [STEP_W-1:0] step,
    output logic              done,
    output logic              err
);
    typedef enum logic [2:0] {S_OP, S_SEL, S_IMM0, S_IMM1, S_EXEC} st_e;

    st_e               st_q;
    dec_t              dec_q;
    dec_t              dec_op;
    dec_t              dec_sel;
    logic [WORD_W-1:0] imm_q;
    logic [STEP_W-1:0] step_q;
    logic              done_q;
    logic              err_q;
    logic              take;
    logic              sext_bit;

    // classify an opcode byte
    function automatic dec_t decode_op(input logic [BYTE_W-1:0] op);
        dec_t d;
        d         = '0;
        d.valid   = 1'b1;
        d.wide    = 1'b1;
        d.kind    = K_ALU;
        casez (op)
            8'b1011_10??: begin d.kind = K_MOV; d.src_imm = 1'b1; d.imm_bytes = 2'd2;
                                d.dst = {1'b0, op[1:0]}; end
            8'b1011_0???: begin d.kind = K_MOV; d.src_imm = 1'b1; d.imm_bytes = 2'd1;
                                d.wide = 1'b0; d.dst = op[2:0]; end
            8'h8B:        begin d.kind = K_MOV; d.need_sel = 1'b1; end
            8'h8A:        begin d.kind = K_MOV; d.need_sel = 1'b1; d.wide = 1'b0; end
            8'h03:        begin d.need_sel = 1'b1; end
            8'h2B:        begin d.need_sel = 1'b1; d.sub = 1'b1; end
            8'h02:        begin d.need_sel = 1'b1; d.wide = 1'b0; end
            8'h2A:        begin d.need_sel = 1'b1; d.wide = 1'b0; d.sub = 1'b1; end
            8'h87:        begin d.kind = K_XCHG; d.need_sel = 1'b1; end
            8'h86:        begin d.kind = K_XCHG; d.need_sel = 1'b1; d.wide = 1'b0; end
            8'h83:        begin d.need_sel = 1'b1; d.rm_ext = 1'b1; d.src_imm = 1'b1;
                                d.imm_bytes = 2'd1; d.imm_sext = 1'b1; end
            8'h05:        begin d.src_imm = 1'b1; d.imm_bytes = 2'd2; end
            8'b0100_00??: begin d.src_imm = 1'b1; d.dst = {1'b0, op[1:0]}; end
            default:      d.valid = 1'b0;
        endcase
        return d;
    endfunction

    // merge a register-selector byte into a decoded opcode and validate it
    function automatic dec_t apply_sel(input dec_t d, input logic [BYTE_W-1:0] m);
        dec_t r;
        r = d;
        if (m[7:6] != 2'b11)
            r.valid = 1'b0;
        if (d.rm_ext) begin
            r.dst = m[2:0];
            r.sub = (m[5:3] == 3'd5);
            if ((m[5:3] != 3'd0) && (m[5:3] != 3'd5))
                r.valid = 1'b0;
        end else begin
            r.dst = m[5:3];
            r.src = m[2:0];
        end
        if (r.wide && (r.dst[CODE_W-1] || (!r.src_imm && r.src[CODE_W-1])))
            r.valid = 1'b0;
        return r;
    endfunction

    // decode both candidate interpretations of the incoming byte
    always_comb begin
        dec_op  = decode_op(in_byte);
        dec_sel = apply_sel(dec_q, in_byte);
    end

    assign take     = in_valid && (st_q != S_EXEC);
    assign sext_bit = dec_q.imm_sext & in_byte[BYTE_W-1];

    // collect bytes, reject bad encodings, step through execution
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_OP;
            dec_q  <= '0;
            imm_q  <= '0;
            step_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (st_q)
                S_OP: if (take) begin
                    imm_q  <= WORD_W'(1);
                    step_q <= '0;
                    if (!dec_op.valid) begin
                        err_q <= 1'b1;
                    end else begin
                        dec_q <= dec_op;
                        if (dec_op.need_sel)            st_q <= S_SEL;
                        else if (dec_op.imm_bytes != 0) st_q <= S_IMM0;
                        else                            st_q <= S_EXEC;
                    end
                end
                S_SEL: if (take) begin
                    if (!dec_sel.valid) begin
                        err_q <= 1'b1;
                        st_q  <= S_OP;
                    end else begin
                        dec_q <= dec_sel;
                        st_q  <= (dec_sel.imm_bytes != 0) ? S_IMM0 : S_EXEC;
                    end
                end
                S_IMM0: if (take) begin
                    imm_q <= {{BYTE_W{sext_bit}}, in_byte};
                    st_q  <= (dec_q.imm_bytes == 2'd2) ? S_IMM1 : S_EXEC;
                end
                S_IMM1: if (take) begin
                    imm_q[WORD_W-1:BYTE_W] <= in_byte;
                    st_q                   <= S_EXEC;
                end
                default: begin
                    if (last) begin
                        st_q   <= S_OP;
                        step_q <= '0;
                        done_q <= 1'b1;
                    end else begin
                        step_q <= step_q + 2'd1;
                    end
                end
            endcase
        end
    end

    assign in_ready = (st_q != S_EXEC);
    assign exec     = (st_q == S_EXEC);
    assign dec      = dec_q;
    assign imm      = imm_q;
    assign step     = step_q;
    assign done     = done_q;
    assign err      = err_q;
endmodule

// File: rtl/sbus_core.sv
// Top level of the single-bus datapath. The sequencer picks a step, the step
// table names one bus driver, and the register file and ALU latches capture
// from that one bus.
// Assumes a byte-serial instruction feed paced by in_ready.
module sbus_core
    import sbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] ax_q,
    output logic [WORD_W-1:0] bx_q,
    output logic [WORD_W-1:0] cx_q,
    output logic [WORD_W-1:0] dx_q
);
    dec_t                         dec;
    ustep_t                       u;
    logic                         exec;
    logic [WORD_W-1:0]            imm;
    logic [STEP_W-1:0]            step;
    logic [WORD_W-1:0]            bus;
    logic [WORD_W-1:0]            rd_data;
    logic [WORD_W-1:0]            z_q;
    logic [CODE_W-1:0]            rd_code;
    logic [CODE_W-1:0]            wr_code;
    logic [NREGS-1:0][WORD_W-1:0] regs;

    sbus_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .last     (u.last),
        .in_ready (in_ready),
        .exec     (exec),
        .dec      (dec),
        .imm      (imm),
        .step     (step),
        .done     (done),
        .err      (err)
    );

    sbus_ustep u_step (
        .exec    (exec),
        .kind    (dec.kind),
        .src_imm (dec.src_imm),
        .sub     (dec.sub),
        .step    (step),
        .u       (u)
    );

    assign rd_code = (u.bus_src == B_RSRC) ? dec.src : dec.dst;
    assign wr_code = (u.wr_sel == W_SRC) ? dec.src : dec.dst;

    // the single shared bus: exactly one driver per cycle
    always_comb begin
        case (u.bus_src)
            B_RDST, B_RSRC: bus = rd_data;
            B_IMM:          bus = imm;
            B_Z:            bus = z_q;
            default:        bus = '0;
        endcase
    end

    sbus_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_code (rd_code),
        .rd_wide (dec.wide),
        .rd_data (rd_data),
        .wr_en   (u.wr_sel != W_NONE),
        .wr_code (wr_code),
        .wr_wide (dec.wide),
        .wr_data (bus),
        .regs_o  (regs)
    );

    sbus_alu u_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .bus   (bus),
        .y_ld  (u.y_ld),
        .z_ld  (u.z_ld),
        .z_op  (u.z_op),
        .wide  (dec.wide),
        .z_q   (z_q)
    );

    assign ax_q = regs[0];
    assign cx_q = regs[1];
    assign dx_q = regs[2];
    assign bx_q = regs[3];
endmodule

// File: rtl/sbus_core_chk.sv
// Checker for sbus_core: port-level timing rules, attached by bind.
module sbus_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        done,
    input logic        err,
    input logic [15:0] ax_q,
    input logic [15:0] bx_q,
    input logic [15:0] cx_q,
    input logic [15:0] dx_q
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);

    assert_collect_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> ($stable(ax_q) && $stable(bx_q) && $stable(cx_q) && $stable(dx_q)));

    assert_err_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(ax_q) && $stable(bx_q) && $stable(cx_q) && $stable(dx_q)));

    assert_err_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (in_ready && !done));

    assert_one_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ax_q != $past(ax_q), bx_q != $past(bx_q),
                    cx_q != $past(cx_q), dx_q != $past(dx_q)}) <= 1);
endmodule

bind sbus_core sbus_core_chk u_chk (.*);

// File: tb/sim_sbus_core.sv
`timescale 1ns/1ps
module sim_sbus_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, done, err;
    logic [15:0] ax_q, bx_q, cx_q, dx_q;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  bq[$];
    logic [63:0] snaps[$];
    logic [63:0] cur = '0;   // model: [15:0]=AX [31:16]=CX [47:32]=DX [63:48]=BX

    always #4 clk = ~clk;

    sbus_core u0 (.*);

    function automatic logic [15:0] getr(logic [63:0] s, int code, bit wide);
        logic [15:0] w;
        w = s[(code % 4) * 16 +: 16];
        if (wide) return w;
        return (code >= 4) ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
    endfunction

    function automatic logic [63:0] putr(logic [63:0] s, int code, bit wide, logic [15:0] v);
        int b;
        b = (code % 4) * 16;
        if (wide)           s[b +: 16]    = v;
        else if (code >= 4) s[b + 8 +: 8] = v[7:0];
        else                s[b +: 8]     = v[7:0];
        return s;
    endfunction

    task automatic chk(bit ok, string tag, logic [65:0] act, logic [65:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h (done,err,BX,DX,CX,AX)", tag, act, exp);
        end
    endtask

    task automatic cyc(string tag, logic [63:0] er, bit ed, bit ee);
        logic [65:0] a, e;
        a = {done, err, bx_q, dx_q, cx_q, ax_q};
        e = {ed, ee, er};
        chk(a === e, tag, a, e);
    endtask

    task automatic rdy(string tag, bit exp);
        chk(in_ready === exp, {tag, " R9 in_ready"}, 66'(in_ready), 66'(exp));
    endtask

    // send bq, then follow snaps one exec cycle at a time
    task automatic run(string tag, bit bad, bit noise, bit gaps);
        logic [63:0] old;
        int n;
        old = cur;
        n = bq.size();
        for (int i = 0; i < n; i++) begin
            rdy(tag, 1'b1);
            in_valid = 1'b1;
            in_byte  = bq[i];
            @(negedge clk);
            in_valid = 1'b0;
            cyc(tag, old, 1'b0, bad && (i == n - 1));
            if (gaps && i != n - 1) begin
                @(negedge clk);
                cyc(tag, old, 1'b0, 1'b0);
            end
        end
        if (bad) begin
            rdy({tag, " R10"}, 1'b1);
            @(negedge clk);
            cyc({tag, " R10 err clears"}, old, 1'b0, 1'b0);
        end else begin
            if (noise) begin
                in_valid = 1'b1;
                in_byte  = 8'h40;
            end
            for (int i = 0; i < snaps.size(); i++) begin
                rdy(tag, 1'b0);
                @(negedge clk);
                if (i == snaps.size() - 1) in_valid = 1'b0;
                cyc({tag, " R11"}, snaps[i], i == snaps.size() - 1, 1'b0);
            end
            rdy(tag, 1'b1);
            cur = snaps[snaps.size() - 1];
        end
        bq.delete();
        snaps.delete();
    endtask

    task automatic mov16(int r, logic [15:0] v, bit gaps);
        bq = '{8'(8'hB8 + r), v[7:0], v[15:8]};
        snaps.push_back(putr(cur, r, 1, v));
        run("R3 mov imm16", 0, 0, gaps);
    endtask

    task automatic mov8(int c, logic [7:0] v);
        bq = '{8'(8'hB0 + c), v};
        snaps.push_back(putr(cur, c, 0, {8'h00, v}));
        run("R2 mov imm8", 0, 0, 0);
    endtask

    task automatic movrr(bit wide, int d, int s, bit noise, string tag);
        bq = '{wide ? 8'h8B : 8'h8A, 8'(8'hC0 | (d << 3) | s)};
        snaps.push_back(putr(cur, d, wide, getr(cur, s, wide)));
        run(tag, 0, noise, 0);
    endtask

    task automatic alurr(bit wide, bit sub, int d, int s);
        logic [15:0] a, b;
        a = getr(cur, d, wide);
        b = getr(cur, s, wide);
        bq = '{wide ? (sub ? 8'h2B : 8'h03) : (sub ? 8'h2A : 8'h02), 8'(8'hC0 | (d << 3) | s)};
        snaps.push_back(cur);
        snaps.push_back(cur);
        snaps.push_back(putr(cur, d, wide, sub ? a - b : a + b));
        run(wide ? "R5 word alu" : "R2 R5 byte alu", 0, 0, 0);
    endtask

    task automatic aluimm8(bit sub, int rm, logic [7:0] ib);
        logic [15:0] a, b;
        a = getr(cur, rm, 1);
        b = {{8{ib[7]}}, ib};
        bq = '{8'h83, 8'(8'hC0 | ((sub ? 5 : 0) << 3) | rm), ib};
        snaps.push_back(cur);
        snaps.push_back(cur);
        snaps.push_back(putr(cur, rm, 1, sub ? a - b : a + b));
        run("R6 imm8", 0, 0, 0);
    endtask

    task automatic addax16(logic [15:0] v);
        bq = '{8'h05, v[7:0], v[15:8]};
        snaps.push_back(cur);
        snaps.push_back(cur);
        snaps.push_back(putr(cur, 0, 1, getr(cur, 0, 1) + v));
        run("R6 imm16", 0, 0, 1);
    endtask

    task automatic incr(int r);
        bq = '{8'(8'h40 + r)};
        snaps.push_back(cur);
        snaps.push_back(cur);
        snaps.push_back(putr(cur, r, 1, getr(cur, r, 1) + 16'd1));
        run("R7 inc", 0, 0, 0);
    endtask

    task automatic xchg(bit wide, int d, int s, bit noise);
        logic [63:0] s1;
        bq = '{wide ? 8'h87 : 8'h86, 8'(8'hC0 | (d << 3) | s)};
        s1 = putr(cur, d, wide, getr(cur, s, wide));
        snaps.push_back(cur);
        snaps.push_back(s1);
        snaps.push_back(putr(s1, s, wide, getr(cur, d, wide)));
        run("R8 xchg", 0, noise, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog act=hung exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cyc("R1 reset", 64'h0, 1'b0, 1'b0);
        rdy("R1", 1'b1);

        mov16(0, 16'hCC6C, 0);             // AX
        movrr(0, 3, 0, 0, "R2 AL->BL");    // low lane
        movrr(0, 7, 4, 0, "R2 AH->BH");    // high lane
        mov16(1, 16'h1234, 1);             // CX, gaps between bytes
        mov16(2, 16'h8001, 0);             // DX
        mov8(5, 8'hA5);                    // CH, CL kept
        mov8(2, 8'h7E);                    // DL, DH kept
        movrr(1, 0, 3, 0, "R4 AX<-BX");
        movrr(1, 0, 1, 0, "R4 AX<-CX");
        movrr(1, 0, 2, 1, "R4 R9 AX<-DX ignored bytes");
        movrr(1, 2, 1, 0, "R4 DX<-CX");

        alurr(1, 0, 0, 3);                 // AX += BX
        alurr(1, 1, 0, 3);                 // AX -= BX
        mov16(0, 16'hFFFF, 0);
        mov16(3, 16'h0001, 0);
        alurr(1, 0, 0, 3);                 // wrap to 0
        alurr(1, 1, 0, 3);                 // borrow to FFFF
        mov16(0, 16'h12FF, 0);
        alurr(0, 0, 0, 3);                 // AL+BL carries out, AH kept
        alurr(0, 1, 4, 3);                 // AH -= BL
        alurr(1, 0, 1, 2);                 // CX += DX

        aluimm8(0, 0, 8'h01);
        aluimm8(0, 0, 8'hFF);              // -1 sign extended
        aluimm8(1, 0, 8'h80);              // subtract -128
        aluimm8(1, 2, 8'h05);
        addax16(16'h1234);

        incr(0); incr(1); incr(2); incr(3);
        mov16(2, 16'hFFFF, 0);
        incr(2);                           // wrap

        mov16(0, 16'hAAAA, 0);
        mov16(3, 16'h5555, 0);
        xchg(1, 0, 3, 0);
        mov16(1, 16'h1E2D, 0);
        xchg(0, 1, 5, 0);                  // CL <-> CH
        xchg(1, 1, 2, 1);                  // CX <-> DX, bytes ignored

        bq = '{8'hBC};             run("R10 opcode BC", 1, 0, 0);
        bq = '{8'h44};             run("R10 opcode 44", 1, 0, 0);
        bq = '{8'hFF};             run("R10 opcode FF", 1, 0, 0);
        bq = '{8'h8B, 8'h03};      run("R10 mod not 11", 1, 0, 0);
        bq = '{8'h8B, 8'hE0};      run("R10 word code 4", 1, 0, 0);
        bq = '{8'h03, 8'hC6};      run("R10 word src 6", 1, 0, 0);
        bq = '{8'h83, 8'hD0};      run("R10 ext 2", 1, 0, 0);
        mov16(0, 16'h0BAD, 0);     // R10 recovery: next byte is an opcode

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule